// File: doc/BRIEF.md
# Multicast Hash Destination Filter

This block decides, on the receive path of a 10G Ethernet MAC, whether an incoming frame is kept, based only on its 48-bit destination address. The address arrives one byte per clock, in wire order, marked by a start strobe on the first byte. While the bytes stream in, the block runs a reflected CRC-32 over them, compares them against the station's own address, and notes whether the address is a group address or the all-ones broadcast address.

On the cycle after the sixth byte, a one-cycle done strobe is raised. It comes with an accept flag and the 9-bit hash index derived from the CRC. Group addresses are accepted when their bucket in a 512-entry, one-bit-per-entry hash table is set. Unicast addresses are accepted only when they equal the station address. Broadcast is always accepted. A promiscuous input accepts everything.

The table is loaded indirectly. Each write of a 32-bit control word sets or clears one entry, and it comes up empty after reset.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset every table entry is clear, so a group (non-broadcast) address is rejected and `flt_done` is low.
- R2: A control write (`ctl_wr_en` high) updates one entry. The entry index is in bits [8:0] of `ctl_wr_data`, and bit 9 is the new value: 1 sets the entry, 0 clears it. Bits [31:10] are ignored.
- R3: `flt_hash` equals bits [31:23] of the bit-reversed result of a CRC-32 over the six address bytes in wire order. The CRC is reflected, uses polynomial 0xEDB88320, is preset to all ones and has no final inversion.
- R4: Bytes are counted from the one presented with `da_sof`. `flt_done` is high for exactly one cycle, in the cycle after the sixth byte is taken, and `flt_accept`/`flt_hash` are valid in that cycle.
- R5: An address whose first byte has bit 0 set is a group address. It is accepted if and only if its table entry is set (unless R7 or R8 applies).
- R6: An address whose first byte has bit 0 clear is accepted if and only if it equals the station address, and the hash table is not consulted. The station address is packed as `own_addr_lo` holding bytes 0 to 3 (byte 0 in bits [7:0]) and `own_addr_hi` holding bytes 4 and 5 (byte 4 in bits [7:0]).
- R7: The all-ones broadcast address is accepted even with an empty table.
- R8: With `promisc_en` high during the last byte, any address is accepted.
- R9: A control write in the same cycle as the last byte of a lookup of the same index does not affect that lookup; it does affect later lookups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wr_data | input | 32 | Control word: index [8:0], entry value [9] |
| own_addr_lo | input | 32 | Station address bytes 0..3, byte 0 in [7:0] |
| own_addr_hi | input | 16 | Station address bytes 4..5, byte 4 in [7:0] |
| promisc_en | input | 1 | Accept every frame |
| da_valid | input | 1 | Destination address byte valid |
| da_sof | input | 1 | Marks the first address byte |
| da_byte | input | 8 | Destination address byte, wire order |
| flt_done | output | 1 | One-cycle result strobe |
| flt_accept | output | 1 | Frame accepted |
| flt_hash | output | 9 | Hash index of the last address |

## Verification
The hash output is compared against an independently computed CRC for several group and unicast addresses, so a wrong bit order, preset or reversal shows up as a mismatch. Group addresses are run with their bucket clear, set and cleared again, and with a different bucket set, which separates a correct lookup from one that reads the wrong entry. Unicast addresses are tried as the station address, as a near miss, and as an address whose bucket is set, which shows the table is skipped for unicast. Broadcast, promiscuous mode, a same-cycle write and lookup, and a full table filled by 512 writes cover the remaining accept paths.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int unsigned CRC_W    = 32;
  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

  // One byte of a reflected CRC-32, LSB of the byte first.
  function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    c = c_in;
    for (int b = 0; b < 8; b++) begin
      if (c[0] ^ d[b]) c = (c >> 1) ^ CRC_POLY;
      else             c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/mhf_hash_table.sv
module mhf_hash_table #(
  parameter int unsigned IDX_W = 9,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_val,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit
);
  logic [DEPTH-1:0] tbl_q, tbl_d;

  always_comb begin
    tbl_d = tbl_q;
    if (wr_en) tbl_d[wr_idx] = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tbl_q <= '0;
    else if (wr_en) tbl_q <= tbl_d;
  end

  // Read sees the table before this cycle's write.
  assign rd_bit = tbl_q[rd_idx];

  AST_WR_TAKES_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tbl_q[$past(wr_idx)] == $past(wr_val)); // R2
  AST_NO_WR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(tbl_q)); // R2
endmodule

// File: rtl/mhf_da_crc.sv
module mhf_da_crc #(
  parameter int unsigned NBYTES = 6,
  localparam int unsigned CNT_W = $clog2(NBYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             da_valid,
  input  logic             da_sof,
  input  logic [7:0]       da_byte,
  output logic             take,
  output logic             last,
  output logic [CNT_W-1:0] pos,
  output logic [31:0]      crc_nxt
);
  import mhf_pkg::*;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [31:0]      crc_q, crc_d, crc_base;

  assign pos  = da_sof ? '0 : cnt_q;
  assign take = da_valid && (da_sof || cnt_q != '0);
  assign last = take && (pos == CNT_W'(NBYTES - 1));

  assign crc_base = da_sof ? CRC_INIT : crc_q;
  assign crc_nxt  = crc_step(crc_base, da_byte);

  always_comb begin
    cnt_d = cnt_q;
    crc_d = crc_q;
    if (take) begin
      crc_d = crc_nxt;
      cnt_d = last ? '0 : pos + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      crc_q <= '0;
    end else if (take) begin
      cnt_q <= cnt_d;
      crc_q <= crc_d;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(NBYTES)); // R4
endmodule

// File: rtl/mhf_da_match.sv
module mhf_da_match #(
  parameter int unsigned NBYTES = 6,
  localparam int unsigned CNT_W = $clog2(NBYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic               da_sof,
  input  logic [CNT_W-1:0]   pos,
  input  logic [7:0]         da_byte,
  input  logic [NBYTES*8-1:0] own_addr,
  output logic               grp_nxt,
  output logic               bc_nxt,
  output logic               own_nxt
);
  logic       grp_q, bc_q, own_q;
  logic [7:0] own_byte;

  assign own_byte = own_addr[{pos, 3'b000} +: 8];

  always_comb begin
    grp_nxt = da_sof ? da_byte[0] : grp_q;
    bc_nxt  = (da_sof ? 1'b1 : bc_q)  && (da_byte == 8'hFF);
    own_nxt = (da_sof ? 1'b1 : own_q) && (da_byte == own_byte);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q <= 1'b0;
      bc_q  <= 1'b0;
      own_q <= 1'b0;
    end else if (take) begin
      grp_q <= grp_nxt;
      bc_q  <= bc_nxt;
      own_q <= own_nxt;
    end
  end

  AST_BC_IS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    bc_q |-> grp_q); // R7
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int unsigned HASH_W = 9,
  parameter int unsigned NBYTES = 6,
  localparam int unsigned CNT_W   = $clog2(NBYTES + 1),
  localparam int unsigned VAL_BIT = HASH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr_en,
  input  logic [31:0]       ctl_wr_data,
  input  logic [31:0]       own_addr_lo,
  input  logic [15:0]       own_addr_hi,
  input  logic              promisc_en,
  input  logic              da_valid,
  input  logic              da_sof,
  input  logic [7:0]        da_byte,
  output logic              flt_done,
  output logic              flt_accept,
  output logic [HASH_W-1:0] flt_hash
);
  logic             take, last;
  logic [CNT_W-1:0] pos;
  logic [31:0]      crc_nxt;
  logic             grp_nxt, bc_nxt, own_nxt, tbl_hit;
  logic [HASH_W-1:0] hash_nxt;
  logic             acc_d;
  logic             done_q, acc_q;
  logic [HASH_W-1:0] hash_q;

  mhf_da_crc #(.NBYTES(NBYTES)) u_crc (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_sof(da_sof),
    .da_byte(da_byte), .take(take), .last(last), .pos(pos), .crc_nxt(crc_nxt)
  );

  mhf_da_match #(.NBYTES(NBYTES)) u_match (
    .clk(clk), .rst_n(rst_n), .take(take), .da_sof(da_sof), .pos(pos),
    .da_byte(da_byte), .own_addr({own_addr_hi, own_addr_lo}),
    .grp_nxt(grp_nxt), .bc_nxt(bc_nxt), .own_nxt(own_nxt)
  );

  // Index = top bits of the bit-reversed CRC: hash bit j is CRC bit HASH_W-1-j.
  for (genvar j = 0; j < HASH_W; j++) begin : g_rev
    assign hash_nxt[j] = crc_nxt[HASH_W-1-j];
  end

  mhf_hash_table #(.IDX_W(HASH_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr_en),
    .wr_idx(ctl_wr_data[HASH_W-1:0]), .wr_val(ctl_wr_data[VAL_BIT]),
    .rd_idx(hash_nxt), .rd_bit(tbl_hit)
  );

  always_comb begin
    acc_d = promisc_en || bc_nxt || (grp_nxt ? tbl_hit : own_nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      hash_q <= '0;
    end else if (last) begin
      acc_q  <= acc_d;
      hash_q <= hash_nxt;
    end
  end

  assign flt_done   = done_q;
  assign flt_accept = acc_q;
  assign flt_hash   = hash_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    flt_done |=> !flt_done); // R4
  AST_DONE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    flt_done |-> $past(da_valid)); // R4
  AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    flt_done && $past(promisc_en) |-> flt_accept); // R8
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(flt_hash) && $stable(flt_accept)); // R4
endmodule

// File: tb/mcast_hash_filter_tb.sv
module mcast_hash_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_wr_en;
  logic [31:0] ctl_wr_data;
  logic [31:0] own_addr_lo;
  logic [15:0] own_addr_hi;
  logic        promisc_en;
  logic        da_valid, da_sof;
  logic [7:0]  da_byte;
  logic        flt_done, flt_accept;
  logic [8:0]  flt_hash;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam logic [47:0] OWN   = 48'h02_11_22_33_44_55;
  localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;

  always #5 clk = ~clk;

  mcast_hash_filter dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .own_addr_lo(own_addr_lo), .own_addr_hi(own_addr_hi), .promisc_en(promisc_en),
    .da_valid(da_valid), .da_sof(da_sof), .da_byte(da_byte),
    .flt_done(flt_done), .flt_accept(flt_accept), .flt_hash(flt_hash)
  );

  // Address written as 48 bits, first wire byte in [47:40].
  function automatic logic [7:0] wbyte(input logic [47:0] a, input int i);
    return a[47-8*i -: 8];
  endfunction

  function automatic logic [8:0] ref_hash(input logic [47:0] a);
    logic [31:0] r, rv;
    logic [7:0]  by;
    logic        fb;
    r = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      by = wbyte(a, i / 8);
      fb = r[0] ^ by[i % 8];
      r  = {1'b0, r[31:1]};
      if (fb) r = r ^ 32'hEDB8_8320;
    end
    for (int k = 0; k < 32; k++) rv[k] = r[31-k];
    return rv[31:23];
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [8:0] idx, input logic val);
    @(negedge clk);
    ctl_wr_en = 1'b1;
    ctl_wr_data = {22'h3FFFFF & {22{~val}}, val, idx};  // upper bits junk when clearing
    @(negedge clk);
    ctl_wr_en = 1'b0;
    ctl_wr_data = '0;
  endtask

  // Sends an address; optional control write alongside the last byte.
  task automatic send(input logic [47:0] a, input logic wr, input logic [31:0] wdata);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      da_valid = 1'b1;
      da_sof   = (i == 0);
      da_byte  = wbyte(a, i);
      if (i == 5 && wr) begin
        ctl_wr_en = 1'b1;
        ctl_wr_data = wdata;
      end
    end
    @(negedge clk);
    da_valid = 1'b0; da_sof = 1'b0; da_byte = '0;
    ctl_wr_en = 1'b0; ctl_wr_data = '0;
  endtask

  task automatic lookup(input logic [47:0] a, input logic exp_acc, input string req);
    send(a, 1'b0, 32'h0);
    chk(flt_done == 1'b1, {req, " done strobe"}, 32'(flt_done), 32'd1);
    chk(flt_accept == exp_acc, req, 32'(flt_accept), 32'(exp_acc));
    chk(flt_hash == ref_hash(a), "R3 hash", 32'(flt_hash), 32'(ref_hash(a)));
    @(negedge clk);
    chk(flt_done == 1'b0, "R4 done one cycle", 32'(flt_done), 32'd0);
  endtask

  task automatic t_reset;
    chk(flt_done == 1'b0, "R1 done low after reset", 32'(flt_done), 32'd0);
    lookup(48'h01_00_5E_00_00_01, 1'b0, "R1 empty table rejects group");
  endtask

  task automatic t_group;
    logic [47:0] a, b;
    a = 48'h01_00_5E_00_00_01;
    b = 48'h01_00_5E_00_00_FB;
    for (int n = 0; n < 16 && ref_hash(a) == ref_hash(b); n++) b = b + 48'd1;
    ctl_write(ref_hash(a), 1'b1);
    lookup(a, 1'b1, "R5 group hit after set (R2)");
    lookup(b, 1'b0, "R5 group other bucket rejected");
    ctl_write(ref_hash(a), 1'b0);
    lookup(a, 1'b0, "R2 cleared entry rejects");
    lookup(48'h33_33_00_00_00_01, 1'b0, "R3 second pattern");
  endtask

  task automatic t_unicast;
    logic [47:0] near;
    lookup(OWN, 1'b1, "R6 own address accepted");
    near = OWN ^ 48'h00_00_00_00_00_01;
    lookup(near, 1'b0, "R6 last byte differs rejected");
    near = OWN ^ 48'h00_00_80_00_00_00;
    ctl_write(ref_hash(near), 1'b1);
    lookup(near, 1'b0, "R6 unicast ignores set bucket");
    ctl_write(ref_hash(near), 1'b0);
  endtask

  task automatic t_bcast_promisc;
    lookup(BCAST, 1'b1, "R7 broadcast accepted");
    @(negedge clk); promisc_en = 1'b1;
    lookup(48'h01_80_C2_00_00_0E, 1'b1, "R8 promisc group");
    lookup(48'h00_AA_BB_CC_DD_EE, 1'b1, "R8 promisc unicast");
    @(negedge clk); promisc_en = 1'b0;
    lookup(48'h00_AA_BB_CC_DD_EE, 1'b0, "R8 promisc off rejects");
  endtask

  task automatic t_same_cycle;
    logic [47:0] a;
    a = 48'h01_00_0C_CC_CC_CD;
    send(a, 1'b1, {22'h0, 1'b1, ref_hash(a)});
    chk(flt_accept == 1'b0, "R9 same-cycle write not seen", 32'(flt_accept), 32'd0);
    lookup(a, 1'b1, "R9 later lookup sees write");
    ctl_write(ref_hash(a), 1'b0);
  endtask

  task automatic t_fill_all;
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      ctl_wr_en = 1'b1;
      ctl_wr_data = 32'h0000_0200 | 32'(i);
    end
    @(negedge clk);
    ctl_wr_en = 1'b0; ctl_wr_data = '0;
    lookup(48'h01_23_45_67_89_AB, 1'b1, "R2 full table group A");
    lookup(48'h09_FE_DC_BA_98_76, 1'b1, "R2 full table group B");
    lookup(48'h00_23_45_67_89_AB, 1'b0, "R6 full table unicast");
  endtask

  initial begin
    rst_n = 1'b0;
    ctl_wr_en = 1'b0; ctl_wr_data = '0;
    own_addr_lo = {wbyte(OWN,3), wbyte(OWN,2), wbyte(OWN,1), wbyte(OWN,0)};
    own_addr_hi = {wbyte(OWN,5), wbyte(OWN,4)};
    promisc_en = 1'b0;
    da_valid = 1'b0; da_sof = 1'b0; da_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_group();
    t_unicast();
    t_bcast_promisc();
    t_same_cycle();
    t_fill_all();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end
endmodule